// File: doc/BRIEF.md
# Interrupt Enable and Wake-up Controller

This block sits between five peripheral interrupt flag sources (a timer overflow, an input-change detector, an external interrupt pin and two comparators) and a CPU. Each raw flag is masked by its own bit in a software-visible enable register. The masked flags are OR-ed together and then gated by a global interrupt enable, which produces a single interrupt request. The global enable is set and cleared by two strobes. These strobes stand in for the CPU's enable-interrupts and disable-interrupts instructions.

The same enable register also holds a wake-up select bit. This bit decides what wakes the CPU from sleep. It is either a change on the port input status, signalled by the input-change flag, or a change in comparator status, signalled by either comparator flag. The chosen source is still qualified by its own per-source enable bit. Wake-up does not depend on the global enable, so a CPU that has interrupts disabled can still be woken.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so state leaves reset a fixed number of clock edges after the input rises.

Top module: `irq_wake_ctrl`

## Requirements
- R1: While reset is active, and after it is released but before any write or strobe, the register reads 0x00 and both `irq_o` and `wake_o` are 0.
- R2: A write with `reg_wr_en` high stores `reg_wdata` bits 5..0 on the next clock edge. The stored value is visible on `reg_rdata` after that edge. The bit positions are: bit 0 timer enable, bit 1 input-change enable, bit 2 external enable, bit 3 wake select, bit 4 comparator-1 enable, bit 5 comparator-2 enable.
- R3: Bits 7 and 6 of `reg_rdata` always read 0, whatever value was written to them.
- R4: `irq_o` is 1 exactly when the global enable is 1 and at least one flag is 1 with its enable bit set to 1. The enable bit for each flag is the one listed in R2. Bit 3 plays no part in `irq_o`.
- R5: A `gie_set` pulse sets the global enable and a `gie_clr` pulse clears it, each on the next clock edge. Between pulses the global enable keeps its value, and writes to the register do not change it.
- R6: When `gie_set` and `gie_clr` are high in the same cycle, the global enable becomes 0.
- R7: With bit 3 set to 0, `wake_o` equals `flag_ic` AND bit 1.
- R8: With bit 3 set to 1, `wake_o` equals (`flag_cmp1` AND bit 4) OR (`flag_cmp2` AND bit 5).
- R9: `wake_o` does not depend on the global enable.
- R10: With `reg_wr_en` low, the register keeps its value, whatever is on `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Write strobe for the enable register |
| reg_wdata | input | 8 | Write data for the enable register |
| reg_rdata | output | 8 | Current contents of the enable register |
| gie_set | input | 1 | Sets the global interrupt enable |
| gie_clr | input | 1 | Clears the global interrupt enable; wins over `gie_set` |
| flag_tmr | input | 1 | Timer overflow flag |
| flag_ic | input | 1 | Port input-change flag |
| flag_ext | input | 1 | External interrupt flag |
| flag_cmp1 | input | 1 | Comparator 1 status-change flag |
| flag_cmp2 | input | 1 | Comparator 2 status-change flag |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench builds the block with its default parameters: an 8-bit register and a two-stage reset synchroniser. With an 8-bit register, every one of the 256 write values can be tried. For each stored value, the bench sweeps all 32 flag combinations with the global enable both off and on. The sweep therefore covers every mask pattern, both wake-up selections and the unused upper bits. The strobe collision case and writes with the strobe low are exercised separately.

// File: rtl/ie_pkg.sv
package ie_pkg;
  // Bit positions inside the enable register.
  localparam int unsigned IE_TMR  = 0;
  localparam int unsigned IE_IC   = 1;
  localparam int unsigned IE_EXT  = 2;
  localparam int unsigned IE_WSEL = 3;
  localparam int unsigned IE_CMP1 = 4;
  localparam int unsigned IE_CMP2 = 5;
  localparam int unsigned IE_USED = 6;
  localparam int unsigned IE_NSRC = 5;

  typedef struct packed {
    logic cmp2;
    logic cmp1;
    logic ext;
    logic ic;
    logic tmr;
  } ie_src_t;
endpackage

// File: rtl/ie_rst_sync.sv
module ie_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ie_enable_reg.sv
module ie_enable_reg
  import ie_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << IE_USED) - 1);

  logic [DATA_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // R10: without a write strobe the register keeps its value
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
  // R3: unused upper bits never become set
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q >> IE_USED) == '0);
endmodule

// File: rtl/ie_irq_gate.sv
module ie_irq_gate
  import ie_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  ie_src_t            flags,
  input  ie_src_t            enables,
  output logic               irq
);
  logic gie_q;
  logic gie_d;
  logic [IE_NSRC-1:0] masked;

  always_comb begin
    gie_d = gie_q;
    if (gie_set) gie_d = 1'b1;
    if (gie_clr) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  for (genvar i = 0; i < IE_NSRC; i++) begin : g_mask
    assign masked[i] = flags[i] & enables[i];
  end

  assign irq = gie_q & (|masked);

  // R5: set strobe alone turns the global enable on
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set && !gie_clr) |=> gie_q);
  // R6: clear strobe always wins
  a_r6_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_q);
  // R4: no request while globally disabled
  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq);
endmodule

// File: rtl/ie_wake_sel.sv
module ie_wake_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_cmp,
  input  logic ic_flag,
  input  logic ic_en,
  input  logic cmp1_flag,
  input  logic cmp1_en,
  input  logic cmp2_flag,
  input  logic cmp2_en,
  output logic wake
);
  logic port_wake;
  logic cmp_wake;

  always_comb begin
    port_wake = ic_flag & ic_en;
    cmp_wake  = (cmp1_flag & cmp1_en) | (cmp2_flag & cmp2_en);
    wake      = sel_cmp ? cmp_wake : port_wake;
  end

  // R7: in port mode only the input-change flag can wake
  a_r7_port_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_cmp && !ic_flag) |-> !wake);
  // R8: in comparator mode the input-change flag alone cannot wake
  a_r8_cmp_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmp && !cmp1_flag && !cmp2_flag) |-> !wake);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import ie_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              flag_tmr,
  input  logic              flag_ic,
  input  logic              flag_ext,
  input  logic              flag_cmp1,
  input  logic              flag_cmp2,
  output logic              irq_o,
  output logic              wake_o
);
  logic              rst_n_int;
  logic [DATA_W-1:0] en_q;
  ie_src_t           src_flags;
  ie_src_t           src_en;

  ie_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ie_enable_reg #(.DATA_W(DATA_W)) u_enable_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .en_q  (en_q)
  );

  always_comb begin
    src_flags.tmr  = flag_tmr;
    src_flags.ic   = flag_ic;
    src_flags.ext  = flag_ext;
    src_flags.cmp1 = flag_cmp1;
    src_flags.cmp2 = flag_cmp2;
    src_en.tmr     = en_q[IE_TMR];
    src_en.ic      = en_q[IE_IC];
    src_en.ext     = en_q[IE_EXT];
    src_en.cmp1    = en_q[IE_CMP1];
    src_en.cmp2    = en_q[IE_CMP2];
  end

  ie_irq_gate u_irq_gate (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .gie_set (gie_set),
    .gie_clr (gie_clr),
    .flags   (src_flags),
    .enables (src_en),
    .irq     (irq_o)
  );

  ie_wake_sel u_wake_sel (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sel_cmp   (en_q[IE_WSEL]),
    .ic_flag   (flag_ic),
    .ic_en     (en_q[IE_IC]),
    .cmp1_flag (flag_cmp1),
    .cmp1_en   (en_q[IE_CMP1]),
    .cmp2_flag (flag_cmp2),
    .cmp2_en   (en_q[IE_CMP2]),
    .wake      (wake_o)
  );

  assign reg_rdata = en_q;

  // R1: outputs quiet while the register is clear
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n_int)
    (en_q == '0) |-> (!irq_o && !wake_o));
endmodule

// File: tb/test_irq_wake_ctrl.sv
module test_irq_wake_ctrl;
  logic       clk;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       gie_set, gie_clr;
  logic       flag_tmr, flag_ic, flag_ext, flag_cmp1, flag_cmp2;
  logic       irq_o, wake_o;

  int checks;
  int failures;
  bit done;

  irq_wake_ctrl i_irq_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .flag_tmr(flag_tmr), .flag_ic(flag_ic), .flag_ext(flag_ext),
    .flag_cmp1(flag_cmp1), .flag_cmp2(flag_cmp2), .irq_o(irq_o), .wake_o(wake_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [4:0] f);
    // f = {cmp2, cmp1, ext, ic, tmr}
    {flag_cmp2, flag_cmp1, flag_ext, flag_ic, flag_tmr} = f;
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wdata = ~v;
  endtask

  task automatic strobe(input logic s, input logic c);
    @(negedge clk);
    gie_set = s;
    gie_clr = c;
    @(negedge clk);
    gie_set = 1'b0;
    gie_clr = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [7:0] r, input logic g, input logic [4:0] f);
    logic any;
    any = (f[0] & r[0]) | (f[1] & r[1]) | (f[2] & r[2]) | (f[3] & r[4]) | (f[4] & r[5]);
    return g & any;
  endfunction

  function automatic logic exp_wake(input logic [7:0] r, input logic [4:0] f);
    if (r[3]) return (f[3] & r[4]) | (f[4] & r[5]);
    return f[1] & r[1];
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    reg_wr_en = 1'b0;
    reg_wdata = 8'h00;
    gie_set = 1'b0;
    gie_clr = 1'b0;
    set_flags(5'h1F);
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", reg_rdata, 8'h00);
    check("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    check("R1 wake in reset", {7'b0, wake_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata after reset", reg_rdata, 8'h00);
    check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    check("R1 wake after reset", {7'b0, wake_o}, 8'h00);

    // R10: write strobe low, data wiggling
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      reg_wdata = 8'hFF ^ 8'(k);
    end
    @(negedge clk);
    check("R10 no write without strobe", reg_rdata, 8'h00);

    // R5 / R6 strobe behaviour, observed through irq with the timer source enabled
    write_reg(8'h01);
    set_flags(5'h01);
    #1 check("R5 gie off initially", {7'b0, irq_o}, 8'h00);
    strobe(1'b1, 1'b0);
    check("R5 set strobe", {7'b0, irq_o}, 8'h01);
    repeat (3) @(negedge clk);
    check("R5 gie holds", {7'b0, irq_o}, 8'h01);
    write_reg(8'h00);
    write_reg(8'h01);
    check("R5 write leaves gie", {7'b0, irq_o}, 8'h01);
    strobe(1'b1, 1'b1);
    check("R6 clear wins", {7'b0, irq_o}, 8'h00);
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    check("R5 clear strobe", {7'b0, irq_o}, 8'h00);

    // Exhaustive sweep: every register value, both gie states, all flag sets
    for (int g = 0; g < 2; g++) begin
      if (g == 1) strobe(1'b1, 1'b0);
      else        strobe(1'b0, 1'b1);
      for (int v = 0; v < 256; v++) begin
        write_reg(8'(v));
        check("R2 R3 readback", reg_rdata, 8'(v) & 8'h3F);
        for (int f = 0; f < 32; f++) begin
          set_flags(5'(f));
          #0.5;
          check("R4 irq", {7'b0, irq_o}, {7'b0, exp_irq(8'(v), 1'(g), 5'(f))});
          if (v[3]) check("R8 R9 wake cmp", {7'b0, wake_o}, {7'b0, exp_wake(8'(v), 5'(f))});
          else      check("R7 R9 wake port", {7'b0, wake_o}, {7'b0, exp_wake(8'(v), 5'(f))});
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule